// File: doc/BRIEF.md
# Window-One Link Acknowledgement Controller

This block runs the numbered-frame side of a LAPD-style data link with a window of one. It keeps the 3-bit send and receive state counters. It forms the control byte of every outgoing information (I) frame and supervisory (S) frame. It watches the N(R) field of incoming frames for the acknowledgement of the single frame it has in flight. The host only asks for an I frame to be sent. Receive responses, timeout polls and retries are all produced inside the block.

After an I frame goes out, an acknowledgement timer counts down from a programmable value. If the timer runs out before a valid acknowledgement arrives, the block polls the peer with an S frame that has the P bit set. It uses RR when the local side can accept data and RNR when it is busy. It repeats this up to a programmable number of times and then reports a link failure. Serial framing, CRC and unnumbered frames are handled elsewhere.

Top module: `lapd_win1_ctl`

## Requirements
- R1: After reset all output strobes are low, `outstanding` is low, and both sequence counters are 0, so the first I frame sent with P=0 has control byte 0x00.
- R2: A request accepted while nothing is outstanding produces, one clock later, a single-cycle `ctl_valid` with `ctl_is_i`=1. The control byte is {V(R)[7:5], P[4], V(S)[3:1], 0[0]}, where P is `tx_pf`. `outstanding` then goes high.
- R3: V(S) advances by one, modulo 8, with each I frame sent and never otherwise.
- R4: A request made while a frame is outstanding is refused: `tx_refused` pulses one clock later, no frame is produced and V(S) does not change.
- R5: A received I or S frame whose N(R) equals the current V(S) while a frame is outstanding pulses `irq_ack` one clock later and clears `outstanding`. Any other N(R) is ignored.
- R6: With no acknowledgement, the first poll appears t_limit+1 clocks after the I frame strobe, counting from the clock of that strobe. Each later poll appears t_limit+1 clocks after the one before it.
- R7: A poll is an S frame with P=1 and N(R)=V(R). It is RR (low nibble 0x1) when `local_busy` is low and RNR (low nibble 0x5) when it is high.
- R8: At most `n2` polls are sent per outstanding frame. The timeout after the last poll pulses `irq_fail` and clears `outstanding`. With `n2`=0, the first timeout reports failure and sends no poll.
- R9: An acknowledgement clears the poll count, so the next I frame again gets the full `n2` polls.
- R10: A received I frame with N(S)=V(R), arriving while `local_busy` is low, advances V(R) modulo 8. One clock later an RR response is sent, carrying the new V(R) and F equal to the received P/F.
- R11: A received I frame that is out of sequence, or that arrives while busy, leaves V(R) unchanged. It is still answered with an S frame carrying the current V(R): RNR if busy, RR otherwise.
- R12: A host request in the same cycle as a received I frame is refused, and the S response is sent instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_req | input | 1 | Host request to send one I frame (single-cycle) |
| tx_pf | input | 1 | P bit for the requested I frame |
| rx_valid | input | 1 | A decoded frame is presented this cycle |
| rx_is_i | input | 1 | 1 = received frame is I, 0 = S |
| rx_ns | input | 3 | N(S) of received I frame |
| rx_nr | input | 3 | N(R) of received frame |
| rx_pf | input | 1 | P/F bit of received frame |
| local_busy | input | 1 | Local receiver cannot accept I frames |
| t_limit | input | TW | Acknowledgement timer reload value |
| n2 | input | RW | Maximum number of polls |
| ctl_byte | output | 8 | Control byte of the frame being sent |
| ctl_valid | output | 1 | Single-cycle send strobe for `ctl_byte` |
| ctl_is_i | output | 1 | The strobed frame is an I frame |
| tx_refused | output | 1 | Host request was refused |
| irq_ack | output | 1 | Outstanding frame acknowledged |
| irq_fail | output | 1 | Poll retries exhausted |
| outstanding | output | 1 | An I frame awaits acknowledgement |

## Verification
The hardest state to reach is an acknowledgement arriving after some polls have already gone out. A bug that fails to reset the poll count only shows up on the next frame, as a shortened retry sequence. The stimulus lets the timer expire once and then acknowledges through a received I frame, which also produces a response. It then sends a new frame and lets it run all the way to failure, so the scoreboard expects exactly `n2` polls in a fixed order. The same-cycle collision of a host request with a received I frame is driven directly. A busy flag raised between two polls checks that the frame type is chosen when each timeout fires.

// File: rtl/lapd_win1_ctl.sv
module lapd_win1_ctl #(
  parameter int TW = 16,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_req,
  input  logic          tx_pf,
  input  logic          rx_valid,
  input  logic          rx_is_i,
  input  logic [2:0]    rx_ns,
  input  logic [2:0]    rx_nr,
  input  logic          rx_pf,
  input  logic          local_busy,
  input  logic [TW-1:0] t_limit,
  input  logic [RW-1:0] n2,
  output logic [7:0]    ctl_byte,
  output logic          ctl_valid,
  output logic          ctl_is_i,
  output logic          tx_refused,
  output logic          irq_ack,
  output logic          irq_fail,
  output logic          outstanding
);

  logic [2:0]    vs, vr;
  logic [TW-1:0] tmr;
  logic [RW-1:0] polls;

  wire       rx_i    = rx_valid & rx_is_i;
  wire       ack_hit = rx_valid & outstanding & (rx_nr == vs);
  wire       in_seq  = rx_i & ~local_busy & (rx_ns == vr);
  wire [2:0] vr_nx   = in_seq ? vr + 3'd1 : vr;
  wire       expire  = outstanding & ~ack_hit & ~rx_i & (tmr == '0);
  wire       give_up = expire & (polls == n2);
  wire       do_poll = expire & ~give_up;
  wire       send_i  = tx_req & ~outstanding & ~rx_i;
  wire [3:0] s_low   = local_busy ? 4'h5 : 4'h1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs          <= '0;
      vr          <= '0;
      tmr         <= '0;
      polls       <= '0;
      outstanding <= 1'b0;
      ctl_byte    <= '0;
      ctl_valid   <= 1'b0;
      ctl_is_i    <= 1'b0;
      tx_refused  <= 1'b0;
      irq_ack     <= 1'b0;
      irq_fail    <= 1'b0;
    end else begin
      ctl_valid  <= send_i | do_poll | rx_i;
      ctl_is_i   <= send_i;
      tx_refused <= tx_req & ~send_i;
      irq_ack    <= ack_hit;
      irq_fail   <= give_up;
      vr         <= vr_nx;

      if (rx_i)         ctl_byte <= {vr_nx, rx_pf, s_low};
      else if (do_poll) ctl_byte <= {vr, 1'b1, s_low};
      else if (send_i)  ctl_byte <= {vr, tx_pf, vs, 1'b0};

      if (send_i) vs <= vs + 3'd1;

      if (send_i)                  outstanding <= 1'b1;
      else if (ack_hit | give_up)  outstanding <= 1'b0;

      if (send_i | do_poll)                 tmr <= t_limit;
      else if (outstanding && tmr != '0)    tmr <= tmr - TW'(1);

      if (send_i | ack_hit)  polls <= '0;
      else if (do_poll)      polls <= polls + RW'(1);
    end
  end

  a_r2_sent_i_is_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && ctl_is_i) |-> outstanding);

  a_r3_vs_follows_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && ctl_is_i) |-> (vs == ctl_byte[3:1] + 3'd1));

  a_r4_refusal_sends_no_i: assert property (@(posedge clk) disable iff (!rst_n)
    tx_refused |-> !(ctl_valid && ctl_is_i));

  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> !outstanding);

  a_r8_fail_clears: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fail |-> !outstanding);

  a_r8_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_ack, irq_fail}));

  a_r10_vr_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_is_i && !local_busy && rx_ns == vr) |=> (vr == $past(vr) + 3'd1));

endmodule

// File: tb/lapd_win1_ctl_test.sv
module lapd_win1_ctl_test;
  localparam int TW = 16;
  localparam int RW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_req = 1'b0, tx_pf = 1'b0;
  logic rx_valid = 1'b0, rx_is_i = 1'b0, rx_pf = 1'b0;
  logic [2:0] rx_ns = '0, rx_nr = '0;
  logic local_busy = 1'b0;
  logic [TW-1:0] t_limit = TW'(200);
  logic [RW-1:0] n2 = RW'(2);
  logic [7:0] ctl_byte;
  logic ctl_valid, ctl_is_i, tx_refused, irq_ack, irq_fail, outstanding;

  lapd_win1_ctl #(.TW(TW), .RW(RW)) uut (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .tx_pf(tx_pf),
    .rx_valid(rx_valid), .rx_is_i(rx_is_i), .rx_ns(rx_ns), .rx_nr(rx_nr),
    .rx_pf(rx_pf), .local_busy(local_busy), .t_limit(t_limit), .n2(n2),
    .ctl_byte(ctl_byte), .ctl_valid(ctl_valid), .ctl_is_i(ctl_is_i),
    .tx_refused(tx_refused), .irq_ack(irq_ack), .irq_fail(irq_fail),
    .outstanding(outstanding));

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [10:0] exp_q[$];
  string tag_q[$];
  logic [2:0] m_vs = '0, m_vr = '0;

  function automatic logic [7:0] ibyte(input logic [2:0] vr, input logic pf, input logic [2:0] vs);
    return {vr, pf, vs, 1'b0};
  endfunction

  function automatic logic [7:0] sbyte(input logic [2:0] vr, input logic pf, input logic busy);
    return {vr, pf, busy ? 4'h5 : 4'h1};
  endfunction

  task automatic push(input logic [2:0] kind, input logic [7:0] b, input string tag);
    exp_q.push_back({kind, b});
    tag_q.push_back(tag);
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic settle;
    @(negedge clk); #1;
  endtask

  task automatic observe(input logic [10:0] ev);
    logic [10:0] e;
    string t;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL unexpected event: actual kind=%0d byte=%h expected none", ev[10:8], ev[7:0]);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (e !== ev) begin
        errors++;
        $display("FAIL %s: actual kind=%0d byte=%h expected kind=%0d byte=%h",
                 t, ev[10:8], ev[7:0], e[10:8], e[7:0]);
      end
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (ctl_valid)  observe({ctl_is_i ? 3'd0 : 3'd1, ctl_byte});
    if (irq_ack)    observe({3'd2, 8'h00});
    if (irq_fail)   observe({3'd3, 8'h00});
    if (tx_refused) observe({3'd4, 8'h00});
  end

  task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_left(input string tag, input int n);
    check_val(tag, exp_q.size(), n);
  endtask

  task automatic host_send(input logic pf, input string tag);
    push(3'd0, ibyte(m_vr, pf, m_vs), tag);
    m_vs = m_vs + 3'd1;
    tx_pf = pf; tx_req = 1'b1;
    step;
    tx_req = 1'b0; tx_pf = 1'b0;
  endtask

  task automatic rx_frame(input logic is_i, input logic [2:0] ns, input logic [2:0] nr, input logic pf);
    rx_is_i = is_i; rx_ns = ns; rx_nr = nr; rx_pf = pf; rx_valid = 1'b1;
    step;
    rx_valid = 1'b0;
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end

  initial begin
    repeat (3) step;
    rst_n = 1'b1;
    settle;
    // R1 reset state
    check_val("R1 strobes", {ctl_valid, tx_refused, irq_ack, irq_fail, outstanding}, 0);

    // R1/R2 first I frame, then S-frame ack (R5)
    host_send(1'b0, "R1 R2 first I frame");
    settle;
    check_left("R2 I frame strobed", 0);
    check_val("R2 outstanding", outstanding, 1);
    push(3'd2, 8'h00, "R5 ack by S frame");
    rx_frame(1'b0, 3'd0, m_vs, 1'b0);
    settle;
    check_left("R5 ack seen", 0);
    check_val("R5 outstanding cleared", outstanding, 0);

    // R2/R3 with P=1, R4 refusal, R5 wrong N(R) ignored
    host_send(1'b1, "R2 R3 I frame P=1");
    push(3'd4, 8'h00, "R4 refused");
    tx_req = 1'b1; step; tx_req = 1'b0;
    settle;
    check_left("R4 refusal only", 0);
    rx_frame(1'b0, 3'd0, m_vs - 3'd1, 1'b0);
    settle; settle;
    check_left("R5 stale N(R) ignored", 0);
    check_val("R5 still outstanding", outstanding, 1);
    push(3'd2, 8'h00, "R5 ack");
    rx_frame(1'b0, 3'd0, m_vs, 1'b0);
    settle;
    check_left("R5 ack seen", 0);

    // R10 in-sequence receive
    m_vr = m_vr + 3'd1;
    push(3'd1, sbyte(m_vr, 1'b1, 1'b0), "R10 RR response F=1");
    rx_frame(1'b1, 3'd0, 3'd5, 1'b1);
    settle;
    check_left("R10 response", 0);
    // R11 out of sequence, then busy
    push(3'd1, sbyte(m_vr, 1'b0, 1'b0), "R11 out-of-seq RR");
    rx_frame(1'b1, 3'd0, 3'd5, 1'b0);
    local_busy = 1'b1;
    push(3'd1, sbyte(m_vr, 1'b0, 1'b1), "R11 busy RNR");
    rx_frame(1'b1, m_vr, 3'd5, 1'b0);
    local_busy = 1'b0;
    settle;
    check_left("R11 responses", 0);

    // R6 R7 R8 timer, polls, failure (t_limit=3, n2=2)
    t_limit = TW'(3);
    host_send(1'b0, "R11 V(R) held, carried in I frame");
    push(3'd1, sbyte(m_vr, 1'b1, 1'b0), "R6 R7 first poll RR");
    repeat (3) step;
    check_left("R6 no poll before timeout", 1);
    step; settle;
    check_left("R6 poll at t_limit+1", 0);
    local_busy = 1'b1;
    push(3'd1, sbyte(m_vr, 1'b1, 1'b1), "R7 second poll RNR");
    push(3'd3, 8'h00, "R8 failure after n2 polls");
    repeat (10) step;
    settle;
    check_left("R8 polls and failure", 0);
    check_val("R8 outstanding cleared", outstanding, 0);
    local_busy = 1'b0;

    // R9 ack after a poll restores full retry count
    host_send(1'b0, "R9 I frame");
    push(3'd1, sbyte(m_vr, 1'b1, 1'b0), "R9 first poll");
    repeat (4) step; settle;
    check_left("R9 first poll", 0);
    m_vr = m_vr + 3'd1;
    push(3'd1, sbyte(m_vr, 1'b0, 1'b0), "R9 R10 response to acking I frame");
    push(3'd2, 8'h00, "R5 R9 ack by I frame");
    rx_frame(1'b1, m_vr - 3'd1, m_vs, 1'b0);
    settle;
    check_left("R9 ack", 0);
    host_send(1'b0, "R9 next I frame");
    push(3'd1, sbyte(m_vr, 1'b1, 1'b0), "R9 poll 1 of 2");
    push(3'd1, sbyte(m_vr, 1'b1, 1'b0), "R9 poll 2 of 2");
    push(3'd3, 8'h00, "R9 failure");
    repeat (14) step; settle;
    check_left("R9 full retry sequence", 0);

    // R8 n2=0
    n2 = RW'(0);
    host_send(1'b0, "R8 I frame n2=0");
    push(3'd3, 8'h00, "R8 immediate failure");
    repeat (6) step; settle;
    check_left("R8 no poll with n2=0", 0);
    n2 = RW'(2);
    t_limit = TW'(200);

    // R3 V(S) wrap
    for (int k = 0; k < 4; k++) begin
      host_send(1'b0, "R3 V(S) wrap");
      push(3'd2, 8'h00, "R3 ack during wrap");
      rx_frame(1'b0, 3'd0, m_vs, 1'b0);
    end
    settle;
    check_left("R3 wrap frames", 0);

    // R10 V(R) wrap
    for (int k = 0; k < 8; k++) begin
      m_vr = m_vr + 3'd1;
      push(3'd1, sbyte(m_vr, 1'b0, 1'b0), "R10 V(R) wrap");
      rx_frame(1'b1, m_vr - 3'd1, 3'd0, 1'b0);
    end
    settle;
    check_left("R10 wrap responses", 0);

    // R12 collision of host request and received I frame
    m_vr = m_vr + 3'd1;
    push(3'd1, sbyte(m_vr, 1'b0, 1'b0), "R12 response wins");
    push(3'd4, 8'h00, "R12 request refused");
    tx_req = 1'b1;
    rx_frame(1'b1, m_vr - 3'd1, 3'd0, 1'b0);
    tx_req = 1'b0;
    settle;
    check_left("R12 collision", 0);
    check_val("R12 nothing outstanding", outstanding, 0);
    host_send(1'b0, "R12 V(S) unchanged after refusal");
    push(3'd2, 8'h00, "R12 ack");
    rx_frame(1'b0, 3'd0, m_vs, 1'b0);
    settle;
    check_left("R12 follow-up", 0);

    repeat (2) step;
    finish_run;
  end
endmodule